// File: doc/BRIEF.md
# Branching Program Counter

This block keeps the address of the next instruction for a small program memory. Every time it is told to advance, it either moves to the following location or takes a jump. In both cases the count wraps inside a program space of 2^ADDR_W words. A jump happens when the instruction's jump bit is set. It also happens when the conditional-jump bit is set and the zero flag from the selected register reads 1. A taken jump loads the low bits of the 10-bit immediate field into the counter.

Advances come from one of two sources. In run mode an internal divider produces a one-cycle tick every DIV_COUNT clocks. In step mode a raw push-button level is synchronised, debounced and reduced to a single pulse for each press. The address is registered and feeds the program memory address directly. The surrounding core drives the jump bit, the conditional bit, the zero flag and the immediate from the fetched word and the register file.

Top module: `branch_pc`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_addr` becomes 0 at that edge, and it reads 0 after reset is released until the first advance.
- R2: When an advance occurs with `jump_bit`=0 and with `cond_bit`=0 or `zero_flag`=0, `pc_addr` becomes (`pc_addr`+1) mod 2^ADDR_W, so the address after 3 is 0 when ADDR_W=2.
- R3: When an advance occurs with `jump_bit`=1, `pc_addr` becomes `target[ADDR_W-1:0]` for any value of `cond_bit` and `zero_flag`. The upper bits of `target` are ignored.
- R4: When an advance occurs with `jump_bit`=0, `cond_bit`=1 and `zero_flag`=1, `pc_addr` becomes `target[ADDR_W-1:0]`.
- R5: With no advance, `pc_addr` holds its value whatever `jump_bit`, `cond_bit`, `zero_flag` and `target` do. In step mode (`run_mode`=0) the internal divider never causes an advance.
- R6: In run mode (`run_mode`=1), the block advances exactly once every DIV_COUNT clock cycles.
- R7: In step mode, each press of `step_btn` (held high, then released, each for longer than the debounce window) causes exactly one advance, however long the button is held.
- R8: In step mode, a high level on `step_btn` that lasts fewer than DEBOUNCE_CYCLES clocks after synchronisation causes no advance.
- R9: A four-word program whose word at address 3 jumps to address 2 visits 0, 1, 2, 3 after reset and then alternates between 2 and 3 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 1 = advance from the internal divider, 0 = advance on button presses |
| step_btn | input | 1 | Raw, asynchronous push-button level |
| jump_bit | input | 1 | Unconditional jump bit of the current instruction |
| cond_bit | input | 1 | Jump-if-zero bit of the current instruction |
| zero_flag | input | 1 | 1 when the selected register holds zero |
| target | input | IMM_W | Immediate field; its low ADDR_W bits are the jump target |
| pc_addr | output | ADDR_W | Registered program memory address |

## Verification
The hardest case to reach from the ports is the step path. A button level has to cross the synchroniser and stay unchanged for the whole debounce window before it can count as a press. A short glitch has to disappear, and a long hold must still give only one advance. The bench shapes the `step_btn` level directly. Genuine presses are held well past the window and the address is checked only after release. Glitches last one or two cycles, and one press is held for many times the window. The self-looping program is produced by deriving `jump_bit` from the current address in run mode, so the bench acts as the program memory.

// File: rtl/branch_pc_pkg.sv
package branch_pc_pkg;

  typedef enum logic {
    SRC_STEP = 1'b0,
    SRC_RUN  = 1'b1
  } adv_src_e;

  typedef struct packed {
    logic jmp;
    logic cnd;
    logic zro;
  } branch_ctl_t;

  function automatic logic take_branch(input branch_ctl_t ctl);
    return ctl.jmp | (ctl.cnd & ctl.zro);
  endfunction

endpackage

// File: rtl/branch_pc_step.sv
module branch_pc_step #(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press_pulse
);
  localparam int DB_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES + 1) : 1;
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   btn_sync;
  logic                   level_q;
  logic [DB_W-1:0]        db_cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= btn_raw;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
      end
    end
  endgenerate

  assign btn_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q     <= 1'b0;
      db_cnt      <= '0;
      press_pulse <= 1'b0;
    end else begin
      press_pulse <= 1'b0;
      if (btn_sync == level_q) begin
        db_cnt <= '0;
      end else if (db_cnt == DB_LAST) begin
        level_q     <= btn_sync;
        db_cnt      <= '0;
        press_pulse <= btn_sync;
      end else begin
        db_cnt <= db_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/branch_pc_div.sv
module branch_pc_div #(
  parameter int DIV_COUNT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic tick
);
  localparam int DV_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT + 1) : 1;
  localparam logic [DV_W-1:0] DV_LAST = DV_W'(DIV_COUNT - 1);

  generate
    if (DIV_COUNT <= 1) begin : g_every
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= enable;
      end
    end else begin : g_count
      logic [DV_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !enable) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else if (cnt == DV_LAST) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt  <= cnt + 1'b1;
          tick <= 1'b0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/branch_pc_core.sv
module branch_pc_core
  import branch_pc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int IMM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  branch_ctl_t       ctl,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] addr_q
);
  logic              load;
  logic [ADDR_W-1:0] next_addr;

  assign load = take_branch(ctl);

  always_comb begin
    if (load) next_addr = imm[ADDR_W-1:0];
    else      next_addr = addr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (advance) addr_q <= next_addr;
  end

endmodule

// File: rtl/branch_pc.sv
module branch_pc
  import branch_pc_pkg::*;
#(
  parameter int ADDR_W          = 2,
  parameter int IMM_W           = 10,
  parameter int DIV_COUNT       = 1000,
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_mode,
  input  logic              step_btn,
  input  logic              jump_bit,
  input  logic              cond_bit,
  input  logic              zero_flag,
  input  logic [IMM_W-1:0]  target,
  output logic [ADDR_W-1:0] pc_addr
);
  adv_src_e    src;
  logic        run_tick;
  logic        step_pulse;
  logic        advance;
  branch_ctl_t ctl;

  assign src = run_mode ? SRC_RUN : SRC_STEP;
  assign ctl = '{jmp: jump_bit, cnd: cond_bit, zro: zero_flag};

  branch_pc_div #(.DIV_COUNT(DIV_COUNT)) u_div (
    .clk    (clk),
    .rst    (rst),
    .enable (src == SRC_RUN),
    .tick   (run_tick)
  );

  branch_pc_step #(
    .SYNC_STAGES     (SYNC_STAGES),
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
  ) u_step (
    .clk         (clk),
    .rst         (rst),
    .btn_raw     (step_btn),
    .press_pulse (step_pulse)
  );

  assign advance = (src == SRC_RUN) ? run_tick : step_pulse;

  branch_pc_core #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .ctl     (ctl),
    .imm     (target),
    .addr_q  (pc_addr)
  );

endmodule

// File: rtl/branch_pc_checker.sv
module branch_pc_checker #(
  parameter int ADDR_W    = 2,
  parameter int IMM_W     = 10,
  parameter int DIV_COUNT = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              run_mode,
  input logic              jump_bit,
  input logic              cond_bit,
  input logic              zero_flag,
  input logic [IMM_W-1:0]  target,
  input logic [ADDR_W-1:0] pc_addr,
  input logic              advance,
  input logic              run_tick,
  input logic              step_pulse
);

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> pc_addr == '0);

  assert_increment_R2: assert property (@(posedge clk) disable iff (rst)
    (advance && !jump_bit && !(cond_bit && zero_flag)) |=>
      pc_addr == ADDR_W'($past(pc_addr) + 1'b1));

  assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && jump_bit) |=> pc_addr == $past(target[ADDR_W-1:0]));

  assert_cond_jump_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !jump_bit && cond_bit && zero_flag) |=>
      pc_addr == $past(target[ADDR_W-1:0]));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pc_addr));

  assert_no_tick_in_step_R5: assert property (@(posedge clk) disable iff (rst)
    !run_mode && $past(!run_mode) |-> !run_tick);

  generate
    if (DIV_COUNT > 1) begin : g_tick_gap
      assert_tick_gap_R6: assert property (@(posedge clk) disable iff (rst)
        run_tick |=> !run_tick);
    end
  endgenerate

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse);

endmodule

bind branch_pc branch_pc_checker #(
  .ADDR_W    (ADDR_W),
  .IMM_W     (IMM_W),
  .DIV_COUNT (DIV_COUNT)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .run_mode   (run_mode),
  .jump_bit   (jump_bit),
  .cond_bit   (cond_bit),
  .zero_flag  (zero_flag),
  .target     (target),
  .pc_addr    (pc_addr),
  .advance    (advance),
  .run_tick   (run_tick),
  .step_pulse (step_pulse)
);

// File: tb/branch_pc_bench.sv
module branch_pc_bench;
  localparam int ADDR_W = 2;
  localparam int IMM_W  = 10;
  localparam int DIV    = 4;
  localparam int DEB    = 3;
  localparam int SETTLE = DEB + 8;
  localparam int MAXCYC = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_mode = 1'b0;
  logic step_btn = 1'b0;
  logic drv_j = 1'b0, drv_c = 1'b0, drv_z = 1'b0;
  logic loop_prog = 1'b0;
  logic [IMM_W-1:0] target = '0;
  logic [ADDR_W-1:0] pc_addr;
  logic jump_bit;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign jump_bit = loop_prog ? (pc_addr == 2'd3) : drv_j;

  branch_pc #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .DIV_COUNT(DIV),
    .SYNC_STAGES(2), .DEBOUNCE_CYCLES(DEB)
  ) u_branch_pc (
    .clk(clk), .rst(rst), .run_mode(run_mode), .step_btn(step_btn),
    .jump_bit(jump_bit), .cond_bit(drv_c), .zero_flag(drv_z),
    .target(target), .pc_addr(pc_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input int hold);
    step_btn = 1'b1;
    cycles(hold);
    step_btn = 1'b0;
    cycles(SETTLE);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cycles(3);
    rst = 1'b0;
    cycles(1);
  endtask

  initial begin
    cycles(MAXCYC);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", MAXCYC, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp;
    int prev;
    int gap;
    int jcz;

    // R1: reset state
    do_reset();
    check("R1 reset", pc_addr, 0);
    cycles(10);
    check("R1 idle after reset", pc_addr, 0);

    // R2 / R3 / R4: sweep all J,C,Z combinations with varied targets
    exp = 0;
    for (int i = 0; i < 128; i++) begin
      jcz = i % 8;
      drv_j = jcz[2];
      drv_c = jcz[1];
      drv_z = jcz[0];
      target = IMM_W'((i * 37 + 5) & 10'h3FF);
      if (drv_j || (drv_c && drv_z)) exp = int'(target[ADDR_W-1:0]);
      else exp = (exp + 1) % 4;
      press(SETTLE);
      if (drv_j) check("R3 jump", pc_addr, exp);
      else if (drv_c && drv_z) check("R4 cond taken", pc_addr, exp);
      else check("R2 increment", pc_addr, exp);
    end

    // R2: explicit wrap from 3 to 0
    drv_j = 0; drv_c = 0; drv_z = 0;
    while (pc_addr != 2'd3) press(SETTLE);
    press(SETTLE);
    check("R2 wrap", pc_addr, 0);

    // R5: no advance while inputs toggle
    prev = pc_addr;
    for (int i = 0; i < 40; i++) begin
      drv_j = i[0]; drv_c = i[1]; drv_z = i[2];
      target = IMM_W'(i * 11);
      @(negedge clk);
    end
    check("R5 hold", pc_addr, prev);

    // R8: short glitches rejected
    drv_j = 0; drv_c = 0; drv_z = 0;
    prev = pc_addr;
    step_btn = 1'b1; cycles(1); step_btn = 1'b0; cycles(SETTLE);
    check("R8 glitch1", pc_addr, prev);
    step_btn = 1'b1; cycles(2); step_btn = 1'b0; cycles(SETTLE);
    check("R8 glitch2", pc_addr, prev);

    // R7: long hold gives one advance
    press(60);
    check("R7 long hold", pc_addr, (prev + 1) % 4);

    // R6: run mode period
    run_mode = 1'b1;
    prev = pc_addr;
    while (pc_addr == prev) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      prev = pc_addr;
      gap = 0;
      while (pc_addr == prev && gap < 50) begin
        @(negedge clk);
        gap++;
      end
      check("R6 period", gap, DIV);
      check("R6 value", pc_addr, (prev + 1) % 4);
    end

    // R5: back to step mode, divider must not advance
    run_mode = 1'b0;
    cycles(2);
    prev = pc_addr;
    cycles(30);
    check("R5 step mode idle", pc_addr, prev);

    // R9: self-looping program
    loop_prog = 1'b1;
    drv_c = 0; drv_z = 0;
    target = 10'h3F6;
    do_reset();
    run_mode = 1'b1;
    exp = 0;
    for (int k = 0; k < 16; k++) begin
      prev = pc_addr;
      gap = 0;
      while (pc_addr == prev && gap < 50) begin
        @(negedge clk);
        gap++;
      end
      exp = (exp == 3) ? 2 : exp + 1;
      check("R9 loop", pc_addr, exp);
    end
    run_mode = 1'b0;
    loop_prog = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule